// File: doc/BRIEF.md
# Bit-Select Escalating Watchdog

This block is a watchdog for a processor's timer facility. It keeps a 64-bit timebase that counts while `tb_en` is high. Software picks a 6-bit period `p`, and that choice selects one timebase bit. Each 0-to-1 transition of that bit is a watchdog event, so the timeout is a power of two in timebase ticks and no reload value is needed.

Events escalate in three stages. The first event after service only sets an arming flag in the status register. The second event sets an interrupt flag and can raise a level interrupt. The third event requests the reset chosen by a 2-bit reset-kind field and records that kind in a field that keeps its value through system reset. Software services the watchdog by writing ones to the two flags. Two 32-bit registers, one for control and one for status, sit behind a simple read/write port with a combinational read.

Top module: `wdog_tbsel`

## Requirements
- R1: After `rst_n` the timebase `tb_now` is 0. It rises by exactly 1 on each clock edge where `tb_en` is 1 and holds its value otherwise.
- R2: The period `p` is split inside control (`reg_sel`=0). Its low two bits are bits 31:30 and its high four bits are bits 20:17. A write puts both parts together, and a read returns them in the same places.
- R3: Period `p` selects timebase bit 63-p. An event is the clock edge where that bit goes from 0 to 1 as the timebase advances, so events fall every 2^(64-p) ticks. When the arming flag (status bit 31) is 0, an event only sets that flag.
- R4: An event while the arming flag is set and the interrupt flag (status bit 30) is clear sets the interrupt flag. `irq` is 1 exactly when the interrupt flag and the interrupt-enable bit (control bit 26) are both 1.
- R5: An event while both flags are set, with a nonzero reset kind (control bits 29:28), gives a one-cycle `rst_req` pulse. In that cycle `rst_kind` holds the reset kind, and the last-reset field (status bits 29:28) becomes that kind. With kind 00 there is no pulse and the status does not change.
- R6: A write to status clears each of bits 31 and 30 that is written as 1. Bits written as 0 are kept, and writes to the last-reset field do nothing. The clear is applied before an event in the same cycle, so that event counts as the first one after service.
- R7: Once the reset kind is nonzero, later control writes leave it unchanged until the next `rst_n`. While it is 00 it can still be written.
- R8: `rst_n` clears the timebase, both flags and all control fields, but keeps the last-reset field. Only `por_n` clears that field.
- R9: Control bits that are not implemented read as 0, and status bits 27:0 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| por_n | input | 1 | Asynchronous active-low power-on reset for the last-reset field |
| tb_en | input | 1 | Timebase advance enable |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 control, 1 status |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register, combinational |
| tb_now | output | 64 | Current timebase value |
| irq | output | 1 | Level watchdog interrupt request |
| rst_req | output | 1 | One-cycle reset request pulse |
| rst_kind | output | 2 | Reset kind of the most recent watchdog reset |

## Verification
For every period from 56 to 63, the timebase is stepped one tick at a time through the point just past the third event. The flags, `irq` and `rst_req` are compared with the event count (t + 2^b) / 2^(b+1), where b is the selected bit. This sweep shows whether the right bit was chosen, whether the event fires on the rising edge and not on the falling edge, and whether the reset stays quiet with kind 00. Separate sequences cover the rest:
- a reset with a nonzero kind, followed by a system reset and then a power-on reset, which shows that the last-reset field survives one reset and not the other;
- a clear that lands in the same cycle as an event, which shows the ordering between the two;
- attempts to rewrite a locked reset kind;
- a clear of one flag only, writes of zeros, and writes to the last-reset field;
- a read of control after writing ones to unimplemented bits.

// File: rtl/wdog_tbsel.sv
module wdog_tbsel #(
  parameter int TB_W = 64,
  parameter int P_W  = 6,
  parameter int D_W  = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           por_n,
  input  logic           tb_en,
  input  logic           reg_wr,
  input  logic           reg_sel,
  input  logic [D_W-1:0] reg_wdata,
  output logic [D_W-1:0] reg_rdata,
  output logic [TB_W-1:0] tb_now,
  output logic           irq,
  output logic           rst_req,
  output logic [1:0]     rst_kind
);
  localparam logic [P_W-1:0] TOP_BIT = P_W'(TB_W - 1);

  logic [TB_W-1:0] tb_q, tb_nxt;
  logic [P_W-1:0]  per_q, bsel;
  logic [1:0]      rc_q, mrr_q;
  logic            ie_q, enw_q, wis_q, fire_q;
  logic            evt, clr_enw, clr_wis, enw_c, wis_c, fire;
  logic            wr_ctl, wr_sts;

  assign tb_nxt  = tb_q + TB_W'(1);
  assign bsel    = TOP_BIT - per_q;
  assign evt     = tb_en & tb_nxt[bsel] & ~tb_q[bsel];

  assign wr_ctl  = reg_wr & ~reg_sel;
  assign wr_sts  = reg_wr & reg_sel;
  assign clr_enw = wr_sts & reg_wdata[31];
  assign clr_wis = wr_sts & reg_wdata[30];
  assign enw_c   = enw_q & ~clr_enw;
  assign wis_c   = wis_q & ~clr_wis;
  assign fire    = evt & enw_c & wis_c & (rc_q != 2'b00);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tb_q <= '0;
    else if (tb_en) tb_q <= tb_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q <= '0;
      ie_q  <= 1'b0;
      rc_q  <= 2'b00;
    end else if (wr_ctl) begin
      per_q <= {reg_wdata[20:17], reg_wdata[31:30]};
      ie_q  <= reg_wdata[26];
      if (rc_q == 2'b00) rc_q <= reg_wdata[29:28];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enw_q  <= 1'b0;
      wis_q  <= 1'b0;
      fire_q <= 1'b0;
    end else begin
      fire_q <= fire;
      enw_q  <= enw_c | evt;
      wis_q  <= wis_c | (evt & enw_c);
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) mrr_q <= 2'b00;
    else if (fire) mrr_q <= rc_q;
  end

  assign reg_rdata = reg_sel
    ? {enw_q, wis_q, mrr_q, 28'b0}
    : {per_q[1:0], rc_q, 1'b0, ie_q, 5'b0, per_q[5:2], 17'b0};
  assign tb_now   = tb_q;
  assign irq      = ie_q & wis_q;
  assign rst_req  = fire_q;
  assign rst_kind = mrr_q;
endmodule

module wdog_tbsel_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        por_n,
  input logic        tb_en,
  input logic [63:0] tb_now,
  input logic        rst_req,
  input logic        enw_q,
  input logic        wis_q,
  input logic [1:0]  rc_q,
  input logic [1:0]  mrr_q
);
  // R1
  tb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tb_en |=> $stable(tb_now));
  // R1
  tb_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tb_en |=> tb_now == $past(tb_now) + 64'd1);
  // R4
  wis_after_enw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wis_q) |-> $past(enw_q));
  // R5
  rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);
  // R5
  rst_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> $past(enw_q && wis_q));
  // R7
  rc_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rc_q) != 2'b00) |-> $stable(rc_q));
  // R8
  mrr_only_fire_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    !$stable(mrr_q) |-> rst_req);
endmodule

bind wdog_tbsel wdog_tbsel_chk u_chk (
  .clk(clk), .rst_n(rst_n), .por_n(por_n), .tb_en(tb_en), .tb_now(tb_now),
  .rst_req(rst_req), .enw_q(enw_q), .wis_q(wis_q), .rc_q(rc_q), .mrr_q(mrr_q)
);

// File: tb/wdog_tbsel_bench.sv
module wdog_tbsel_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0, por_n = 1'b0, tb_en = 1'b0;
  logic        reg_wr = 1'b0, reg_sel = 1'b0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [63:0] tb_now;
  logic        irq, rst_req;
  logic [1:0]  rst_kind;
  int total = 0, bad = 0, cyc_n = 0;

  always #10 clk = ~clk;

  wdog_tbsel u_wdog_tbsel (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .tb_en(tb_en), .reg_wr(reg_wr),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tb_now(tb_now), .irq(irq), .rst_req(rst_req), .rst_kind(rst_kind)
  );

  always @(posedge clk) begin
    cyc_n <= cyc_n + 1;
    if (cyc_n > 150000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: run hung, actual=%0d cycles expected<150000", cyc_n);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic logic [31:0] mk(input logic [5:0] p, input logic [1:0] rc, input logic ie);
    return {p[1:0], rc, 1'b0, ie, 5'b0, p[5:2], 17'b0};
  endfunction

  task automatic chk(input string req, input logic [95:0] act, input logic [95:0] exp);
    total = total + 1;
    if (act !== exp) begin
      bad = bad + 1;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic tick(input int n);
    tb_en = 1'b1;
    repeat (n) step();
    tb_en = 1'b0;
  endtask

  task automatic wr(input logic sel, input logic [31:0] d, input logic en);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d; tb_en = en;
    step();
    reg_wr = 1'b0; tb_en = 1'b0;
  endtask

  task automatic rd(input logic sel, output logic [31:0] d);
    reg_sel = sel;
    #1 d = reg_rdata;
  endtask

  task automatic sys_reset();
    rst_n = 1'b0;
    step();
    rst_n = 1'b1;
    step();
  endtask

  initial begin
    logic [31:0] d;
    @(negedge clk);
    step();
    por_n = 1'b1;
    rst_n = 1'b1;
    step();

    // R1 R8 R9: reset state
    rd(1'b1, d); chk("R8 status after reset", d, 32'h0);
    rd(1'b0, d); chk("R8 control after reset", d, 32'h0);
    chk("R1 timebase after reset", {tb_now, irq, rst_req}, {64'h0, 2'b00});

    // R1: hold without enable
    tick(3);
    repeat (4) step();
    chk("R1 timebase holds", tb_now, 64'd3);

    // R2 R9: field placement and unimplemented bits
    wr(1'b0, mk(6'h2D, 2'b00, 1'b1) | 32'h0801_FFFF, 1'b0);
    rd(1'b0, d); chk("R2 R9 control readback", d, mk(6'h2D, 2'b00, 1'b1));

    // R3 R4 R5: sweep periods, kind 00, one tick at a time
    for (int p = 56; p <= 63; p++) begin
      int b, t_end, ok;
      b = 63 - p;
      t_end = (1 << b) + (1 << (b + 2)) + 1;
      sys_reset();
      wr(1'b0, mk(6'(p), 2'b00, 1'b1), 1'b0);
      ok = 1;
      for (int t = 1; t <= t_end; t++) begin
        int e;
        logic [31:0] s;
        tick(1);
        e = (t + (1 << b)) >> (b + 1);
        rd(1'b1, s);
        if ({tb_now, s, irq, rst_req} !== {64'(t), (e >= 1), (e >= 2), 30'b0, (e >= 2), 1'b0}) begin
          chk($sformatf("R3 R4 R5 sweep p=%0d t=%0d", p, t),
              {tb_now, s[31:30], irq, rst_req},
              {64'(t), (e >= 1), (e >= 2), (e >= 2), 1'b0});
          ok = 0;
        end
      end
      if (ok) chk($sformatf("R3 R4 R5 sweep p=%0d", p), 1, 1);
    end

    // R5 R8: reset action, then system reset and power-on reset
    sys_reset();
    wr(1'b0, mk(6'd63, 2'b10, 1'b1), 1'b0);
    tick(4);
    rd(1'b1, d); chk("R4 both flags set", {d, irq, rst_req}, {32'hC000_0000, 2'b10});
    tick(1);
    chk("R5 reset pulse and kind", {rst_req, rst_kind}, {1'b1, 2'b10});
    step();
    chk("R5 pulse one cycle", rst_req, 1'b0);
    rd(1'b1, d); chk("R5 last-reset field", d[29:28], 2'b10);
    sys_reset();
    rd(1'b1, d); chk("R8 last-reset kept through rst_n", d, 32'h2000_0000);
    rd(1'b0, d); chk("R8 control cleared", {d, tb_now}, {32'h0, 64'h0});
    por_n = 1'b0; step(); por_n = 1'b1; step();
    rd(1'b1, d); chk("R8 power-on clears last-reset", {d, rst_kind}, {32'h0, 2'b00});

    // R7: reset kind lock
    sys_reset();
    wr(1'b0, mk(6'd63, 2'b00, 1'b0), 1'b0);
    wr(1'b0, mk(6'd63, 2'b01, 1'b0), 1'b0);
    rd(1'b0, d); chk("R7 kind writable while 00", d[29:28], 2'b01);
    wr(1'b0, mk(6'd63, 2'b11, 1'b0), 1'b0);
    rd(1'b0, d); chk("R7 kind locked vs 11", d[29:28], 2'b01);
    wr(1'b0, mk(6'd62, 2'b00, 1'b1), 1'b0);
    rd(1'b0, d); chk("R7 kind locked vs 00, others update", d, mk(6'd62, 2'b01, 1'b1));
    sys_reset();
    rd(1'b0, d); chk("R7 unlock by rst_n", d[29:28], 2'b00);

    // R4: interrupt enable off
    wr(1'b0, mk(6'd63, 2'b00, 1'b0), 1'b0);
    tick(3);
    rd(1'b1, d); chk("R4 no irq when disabled", {d, irq}, {32'hC000_0000, 1'b0});

    // R6: write-one-to-clear
    sys_reset();
    wr(1'b0, mk(6'd63, 2'b00, 1'b1), 1'b0);
    tick(3);
    wr(1'b1, 32'h4000_0000, 1'b0);
    rd(1'b1, d); chk("R6 clear interrupt flag only", {d, irq}, {32'h8000_0000, 1'b0});
    wr(1'b1, 32'h3FFF_FFFF, 1'b0);
    rd(1'b1, d); chk("R6 zeros and last-reset writes ignored", d, 32'h8000_0000);
    tick(2);
    rd(1'b1, d); chk("R6 escalates after partial clear", d, 32'hC000_0000);
    tick(1);
    wr(1'b1, 32'hC000_0000, 1'b1);
    rd(1'b1, d); chk("R6 clear before same-cycle event", {d, tb_now}, {32'h8000_0000, 64'd7});

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule